// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the addresses for a four-beat burst access from a single starting address. When a load is requested, the full presented address is captured and becomes beat 0. Each later cycle in which the active-low advance input is asserted moves the burst to the next beat. Only the two low address bits change during a burst. The upper bits stay equal to the loaded value until the next load.

An order-select input chooses one of two beat orders. Linear order counts upward from the starting low bits and wraps inside the aligned four-word block. Interleaved order XORs the starting low bits with the beat number. The order is captured together with the address at load time, so one burst always uses one order. After the fourth beat, a further advance returns to the starting address. A new load at any point restarts the sequence.

Both outputs come from registers. They change on the clock edge that samples the load or the advance. The memory array and the data path sit outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `addr_out` is all zeros and `beat` is 0.
- R2: When `load` is 1 at a rising edge, `addr_out` equals the sampled `addr_in` after that edge and `beat` is 0. This holds whatever the value of `adv_n`.
- R3: When `load` is 0 and `adv_n` is 0 at a rising edge, `beat` increases by one, modulo 4, after that edge.
- R4: When `load` is 0 and `adv_n` is 1 at a rising edge, `addr_out` and `beat` keep their values.
- R5: Bits `addr_out[ADDR_W-1:2]` change only on a load. Low-bit stepping never carries into them.
- R6: When `ord_lin` was 1 at the last load, `addr_out[1:0]` equals (start low bits + `beat`) modulo 4.
- R7: When `ord_lin` was 0 at the last load, `addr_out[1:0]` equals the start low bits XOR `beat`.
- R8: An advance taken while `beat` is 3 returns `addr_out` to the loaded address, with `beat` 0.
- R9: `ord_lin` is sampled only on a load. Changing it during a burst does not change the order.
- R10: A load in the middle of a burst restarts the sequence from the new address at beat 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture `addr_in` and `ord_lin`, and start a burst |
| adv_n | input | 1 | Active-low request to step to the next beat |
| ord_lin | input | 1 | Order select: 1 linear, 0 interleaved |
| addr_in | input | ADDR_W | Starting address presented for a load |
| addr_out | output | ADDR_W | Current burst address |
| beat | output | 2 | Current beat index, 0 to 3 |

## Verification
Every result of this block is due exactly one rising edge after the cycle that presents the stimulus. This applies to a load capture, an advance step, a held cycle and a wrap alike. The driver changes the inputs on the falling edge and pushes one expected address and beat per cycle, taken from a reference model of the two orders. The monitor pops that entry 5 ns after the next rising edge and compares it there. Each comparison therefore falls in the single cycle in which the registered outputs must reflect that stimulus.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Beat ordering captured with each load.
    typedef enum logic {
        ORDER_XOR  = 1'b0,
        ORDER_WRAP = 1'b1
    } order_e;

endpackage

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv_n,
    output logic [BEAT_W-1:0] beat
);

    typedef struct packed {
        logic [BEAT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    // Load has priority; an advance steps the count and wraps naturally.
    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = '0;
        end else if (!adv_n) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat = st_q.cnt;

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_addr_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_low,
    input  logic [BEAT_W-1:0] beat,
    input  order_e            order,
    output logic [BEAT_W-1:0] low_out
);

    logic [BEAT_W-1:0] wrap_low;
    logic [BEAT_W-1:0] xor_low;

    // Linear order: add inside the aligned block, carry discarded.
    assign wrap_low = start_low + beat;

    // Interleaved order: each bit flips independently.
    for (genvar i = 0; i < BEAT_W; i++) begin : g_xor_bit
        assign xor_low[i] = start_low[i] ^ beat[i];
    end

    always_comb begin
        unique case (order)
            ORDER_WRAP: low_out = wrap_low;
            default:    low_out = xor_low;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv_n,
    input  logic              ord_lin,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BEAT_W-1:0] beat
);

    localparam int UPPER_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        logic [BEAT_W-1:0]  start_low;
        order_e             order;
    } base_state_t;

    base_state_t st_d, st_q;
    logic [BEAT_W-1:0] low_bits;

    // Base address and order change only on a load.
    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.upper     = addr_in[ADDR_W-1:BEAT_W];
            st_d.start_low = addr_in[BEAT_W-1:0];
            st_d.order     = order_e'(ord_lin);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.upper     <= '0;
            st_q.start_low <= '0;
            st_q.order     <= ORDER_WRAP;
        end else begin
            st_q <= st_d;
        end
    end

    burst_beat_cnt #(
        .BEAT_W (BEAT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv_n (adv_n),
        .beat  (beat)
    );

    burst_order_map #(
        .BEAT_W (BEAT_W)
    ) u_map (
        .start_low (st_q.start_low),
        .beat      (beat),
        .order     (st_q.order),
        .low_out   (low_bits)
    );

    assign addr_out = {st_q.upper, low_bits};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load,
    input logic              adv_n,
    input logic              ord_lin,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic [BEAT_W-1:0] beat
);

    logic [ADDR_W-1:0] ref_addr;
    logic              ref_lin;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_addr <= '0;
            ref_lin  <= 1'b1;
        end else if (load) begin
            ref_addr <= addr_in;
            ref_lin  <= ord_lin;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (addr_out == '0 && beat == '0));

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_out == $past(addr_in) && beat == '0));

    // R3
    advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv_n) |=> beat == BEAT_W'($past(beat) + 1'b1));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv_n) |=> ($stable(addr_out) && $stable(beat)));

    // R5
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

    // R6
    linear_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_lin |-> addr_out[BEAT_W-1:0] == BEAT_W'(ref_addr[BEAT_W-1:0] + beat));

    // R7
    xor_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_lin |-> addr_out[BEAT_W-1:0] == (ref_addr[BEAT_W-1:0] ^ beat));

    // R8
    wrap_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv_n && beat == {BEAT_W{1'b1}}) |=> (addr_out == ref_addr && beat == '0));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .adv_n    (adv_n),
    .ord_lin  (ord_lin),
    .addr_in  (addr_in),
    .addr_out (addr_out),
    .beat     (beat)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

    localparam int AW = 17;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic          adv_n = 1'b1;
    logic          ord_lin = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic [BW-1:0] beat;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [BW-1:0] beat;
        string         req;
    } exp_t;

    exp_t sb[$];

    logic [AW-1:0] m_base = '0;
    logic          m_lin = 1'b1;
    logic [BW-1:0] m_beat = '0;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BEAT_W(BW)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv_n    (adv_n),
        .ord_lin  (ord_lin),
        .addr_in  (addr_in),
        .addr_out (addr_out),
        .beat     (beat)
    );

    // Driver: one call per cycle, expectation due after the next rising edge.
    task automatic drive(input logic ld, input logic an, input logic ol,
                         input logic [AW-1:0] a, input string req);
        exp_t e;
        logic [BW-1:0] low;
        @(negedge clk);
        load = ld; adv_n = an; ord_lin = ol; addr_in = a;
        if (ld) begin
            m_base = a; m_lin = ol; m_beat = '0;
        end else if (!an) begin
            m_beat = m_beat + 1'b1;
        end
        low = m_lin ? BW'(m_base[BW-1:0] + m_beat) : (m_base[BW-1:0] ^ m_beat);
        e.addr = {m_base[AW-1:BW], low};
        e.beat = m_beat;
        e.req  = req;
        sb.push_back(e);
    endtask

    // Monitor: compares mid-high phase after each rising edge.
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                checks++;
                if (addr_out !== e.addr || beat !== e.beat) begin
                    errors++;
                    $display("FAIL %s addr=%h beat=%0d expected addr=%h beat=%0d",
                             e.req, addr_out, beat, e.addr, e.beat);
                end
            end
        end
    end

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog addr=%h beat=%0d expected completion", addr_out, beat);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        checks++;
        if (addr_out !== '0 || beat !== '0) begin
            errors++;
            $display("FAIL R1 addr=%h beat=%0d expected addr=0 beat=0", addr_out, beat);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R4: first cycle out of reset, idle hold
        drive(0, 1, 1, '0, "R1");
        drive(0, 1, 1, 17'h1ABCD, "R4");
        // R3: advance from reset base
        drive(0, 0, 1, '0, "R3");
        // R2 / R6: linear burst from low bits 2
        drive(1, 1, 1, 17'h0A5A2, "R2");
        drive(0, 0, 1, '0, "R6");
        drive(0, 1, 1, '0, "R4");
        drive(0, 0, 1, '0, "R6");
        drive(0, 0, 1, '0, "R6");
        drive(0, 0, 1, '0, "R8");
        drive(0, 0, 1, '0, "R3");
        // R7: interleaved burst from low bits 1
        drive(1, 1, 0, 17'h1F3C1, "R2");
        drive(0, 0, 0, '0, "R7");
        // R9: order input flipped mid-burst has no effect
        drive(0, 0, 1, '0, "R9");
        drive(0, 0, 1, '0, "R9");
        drive(0, 0, 0, '0, "R8");
        // R7: interleaved from low bits 2
        drive(1, 1, 0, 17'h00F42, "R2");
        drive(0, 0, 0, '0, "R7");
        drive(0, 0, 0, '0, "R7");
        drive(0, 0, 0, '0, "R7");
        // R5: linear from all-ones, no carry into upper bits
        drive(1, 0, 1, 17'h1FFFF, "R2");
        drive(0, 0, 0, '0, "R5");
        drive(0, 0, 0, '0, "R5");
        drive(0, 1, 0, 17'h00000, "R5");
        // R10: reload mid-burst with advance also asserted
        drive(1, 0, 0, 17'h12343, "R10");
        drive(0, 0, 0, '0, "R10");
        drive(1, 1, 1, 17'h00001, "R10");
        drive(0, 0, 1, '0, "R6");
        drive(0, 0, 1, '0, "R6");
        drive(0, 0, 1, '0, "R6");
        drive(0, 0, 1, '0, "R8");
        drive(0, 1, 1, '0, "R4");

        repeat (3) @(posedge clk);
        #6;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule